// File: doc/BRIEF.md
# Three-Channel Packed Curve Lookup

This block applies a per-channel transfer curve to a stream of RGB pixels. Each of the red, green and blue channels has its own table of 16-bit points. A component picks a segment of its channel's curve with its upper bits. Its lower bits then interpolate linearly between the two points that bound that segment. The same block serves as a linearising (input) curve stage or a re-encoding (output) curve stage. The parameter `CURVE_KIND` chooses between them: 0 gives 33 points per channel, 1 gives 41.

Software fills the tables through three simple registers. The first is a pointer register that sets the load position. The second is a data register that takes two points per 32-bit write and steps the pointer on by itself. The third is a control register that holds the per-channel enables. The three tables are stored one after another in the order red, green, blue. Because each table has an odd length, one data word holds the last red point and the first green point. Pixel results appear two cycles after the pixel is accepted. The tables must not be loaded while pixels are streaming.

Top module: `curve_lut`

## Requirements
- R1: A write to register 1 (pointer) sets the load pointer to `wr_data[6:0]`, clamped to the total point count. Writing 0 selects red point 0.
- R2: A write to register 2 (data) stores `wr_data[15:0]` at the pointer and `wr_data[31:16]` at pointer+1, then advances the pointer by two.
- R3: The flat point order is red 0..N-1, then green 0..N-1, then blue 0..N-1. The data word that starts at red point N-1 carries that point in its low half and green point 0 in its high half.
- R4: No point beyond the last blue point is ever written. The high half of the word that starts at the last blue point is discarded. Further data writes change no point, and the pointer never wraps back to red.
- R5: N is 33 points per channel when `CURVE_KIND`=0 and 41 when `CURVE_KIND`=1.
- R6: Register 0 (control) holds a 3-bit enable field with red in the lowest bit. The field sits at bits 29:27 for `CURVE_KIND`=0 and at bits 31:29 for `CURVE_KIND`=1. When a channel's enable is clear, that channel's output equals its input component, zero-extended to 16 bits.
- R7: For `CURVE_KIND`=0, bit 31 of register 0 arms the lookup. While it is clear, all three channels bypass, whatever the enables say.
- R8: With F = 10 - clog2(N-1), a component c gives k = c>>F and f = c mod 2^F. The output is e[k] + floor((e[k+1]-e[k])*f / 2^F).
- R9: When k >= N-1, the output is e[N-1]. This is reachable only when `CURVE_KIND`=1.
- R10: `out_vld` rises exactly two cycles after `pix_vld`, and the bench sees exactly one result for each accepted pixel.
- R11: After reset, `out_vld` is 0, the outputs are 0, every channel bypasses and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 pointer, 2 data |
| wr_data | input | 32 | Register write data |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | PIX_W | Red component |
| pix_g | input | PIX_W | Green component |
| pix_b | input | PIX_W | Blue component |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 16 | Red result |
| out_g | output | 16 | Green result |
| out_b | output | 16 | Blue result |

## Verification
The 33-point and 41-point variants run side by side on the same pixels, each with three different curves: identity, quadratic and falling. The falling curve exercises the floor of a negative interpolation step. Components of 0, full scale, exact segment starts and mid-segment values separate indexing errors from weighting errors. Red at full scale combined with green near zero shows whether the word straddling red and green was split correctly. Later partial reloads of the tables, together with enable patterns placed at the other variant's bit positions, show whether the pointer and the control fields are decoded correctly.

// File: rtl/curve_lut_pkg.sv
package curve_lut_pkg;
  localparam int ENT_W = 16;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PTR  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  function automatic int curve_pts(input int kind);
    return (kind != 0) ? 41 : 33;
  endfunction

  function automatic int curve_en_lsb(input int kind);
    return (kind != 0) ? 29 : 27;
  endfunction
endpackage

// File: rtl/curve_lut_rst_sync.sv
module curve_lut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/curve_lut_loader.sv
module curve_lut_loader #(
  parameter int TOT   = 99,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic             data_wr,
  input  logic [31:0]      wr_data,
  output logic [PTR_W-1:0] ptr,
  output logic             lo_we,
  output logic             hi_we,
  output logic [PTR_W-1:0] lo_idx,
  output logic [PTR_W-1:0] hi_idx,
  output logic [15:0]      lo_val,
  output logic [15:0]      hi_val
);
  localparam logic [PTR_W-1:0] TOT_P = PTR_W'(TOT);

  logic [PTR_W-1:0] ptr_q, ptr_d, set_v;

  assign set_v = wr_data[PTR_W-1:0];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr)
      ptr_d = (set_v > TOT_P) ? TOT_P : set_v;
    else if (data_wr)
      ptr_d = (ptr_q >= TOT_P - 1'b1) ? TOT_P : ptr_q + PTR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (ptr_wr || data_wr) ptr_q <= ptr_d;
  end

  // a word starting at the last point keeps only its low half
  assign lo_we  = data_wr && (ptr_q < TOT_P);
  assign hi_we  = data_wr && (ptr_q < TOT_P - 1'b1);
  assign lo_idx = ptr_q;
  assign hi_idx = ptr_q + 1'b1;
  assign lo_val = wr_data[15:0];
  assign hi_val = wr_data[31:16];
  assign ptr    = ptr_q;
endmodule

// File: rtl/curve_lut_store.sv
module curve_lut_store #(
  parameter int TOT   = 99,
  parameter int PTR_W = 7
) (
  input  logic                                 clk,
  input  logic                                 lo_we,
  input  logic                                 hi_we,
  input  logic [PTR_W-1:0]                     lo_idx,
  input  logic [PTR_W-1:0]                     hi_idx,
  input  logic [15:0]                          lo_val,
  input  logic [15:0]                          hi_val,
  output logic [TOT-1:0][curve_lut_pkg::ENT_W-1:0] tbl
);
  // points: red block, green block, blue block, back to back
  always_ff @(posedge clk) begin
    for (int i = 0; i < TOT; i++) begin
      if (lo_we && (lo_idx == PTR_W'(i)))      tbl[i] <= lo_val;
      else if (hi_we && (hi_idx == PTR_W'(i))) tbl[i] <= hi_val;
    end
  end
endmodule

// File: rtl/curve_lut_chan.sv
module curve_lut_chan #(
  parameter int N      = 33,
  parameter int PIX_W  = 10,
  parameter int IDX_W  = 5,
  parameter int FRAC_W = 5,
  parameter int SEL_W  = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                stage_a_en,
  input  logic                                stage_b_en,
  input  logic                                bypass,
  input  logic [PIX_W-1:0]                    comp,
  input  logic [N-1:0][curve_lut_pkg::ENT_W-1:0] curve,
  output logic [curve_lut_pkg::ENT_W-1:0]     res
);
  import curve_lut_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    idx_x;
  logic              sat;
  logic [SEL_W-1:0]  sel_lo, sel_hi;
  logic [ENT_W-1:0]  lo_d, hi_d, lo_q, hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic              byp_q;
  logic [PIX_W-1:0]  raw_q;
  logic signed [ENT_W:0]          diff;
  logic signed [ENT_W+FRAC_W+1:0] prod;
  logic [ENT_W-1:0]  res_d, res_q;

  // stage A: segment select and point fetch
  always_comb begin
    idx    = comp[PIX_W-1 -: IDX_W];
    idx_x  = {1'b0, idx};
    sat    = idx_x >= (IDX_W+1)'(N-1);
    sel_lo = sat ? SEL_W'(N-1) : SEL_W'(idx_x);
    sel_hi = sat ? SEL_W'(N-1) : SEL_W'(idx_x + 1'b1);
    lo_d   = curve[sel_lo];
    hi_d   = curve[sel_hi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
      byp_q  <= 1'b1;
      raw_q  <= '0;
    end else if (stage_a_en) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      frac_q <= comp[FRAC_W-1:0];
      byp_q  <= bypass;
      raw_q  <= comp;
    end
  end

  // stage B: weighted step between the two points
  always_comb begin
    diff  = $signed({1'b0, hi_q}) - $signed({1'b0, lo_q});
    prod  = diff * $signed({1'b0, frac_q});
    res_d = byp_q ? ENT_W'(raw_q) : lo_q + ENT_W'(prod >>> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          res_q <= '0;
    else if (stage_b_en) res_q <= res_d;
  end

  assign res = res_q;
endmodule

// File: rtl/curve_lut.sv
module curve_lut #(
  parameter int CURVE_KIND = 0,
  parameter int PIX_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  output logic             out_vld,
  output logic [15:0]      out_r,
  output logic [15:0]      out_g,
  output logic [15:0]      out_b
);
  import curve_lut_pkg::*;

  localparam int N      = curve_pts(CURVE_KIND);
  localparam int TOT    = 3 * N;
  localparam int PTR_W  = $clog2(TOT + 2);
  localparam int IDX_W  = $clog2(N - 1);
  localparam int FRAC_W = PIX_W - IDX_W;
  localparam int SEL_W  = $clog2(N);
  localparam int EN_LSB = curve_en_lsb(CURVE_KIND);

  logic rst_s;
  logic ctrl_wr, ptr_wr, data_wr;
  logic [2:0] en_q, en_d;
  logic arm_q, arm_d, active;
  logic vld_a_q, vld_b_q;
  logic [PTR_W-1:0] ld_ptr, lo_idx, hi_idx;
  logic lo_we, hi_we;
  logic [15:0] lo_val, hi_val;
  logic [TOT-1:0][ENT_W-1:0] tbl;
  logic [PIX_W-1:0] comp_v [3];
  logic [ENT_W-1:0] res_v [3];

  curve_lut_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s));

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign ptr_wr  = wr_en && (wr_addr == REG_PTR);
  assign data_wr = wr_en && (wr_addr == REG_DATA);

  always_comb begin
    en_d  = wr_data[EN_LSB +: 3];
    arm_d = wr_data[31];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q  <= 3'b000;
      arm_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q  <= en_d;
      arm_q <= arm_d;
    end
  end

  // the output-curve variant has no arm bit: bit 31 is its blue enable
  assign active = (CURVE_KIND != 0) ? 1'b1 : arm_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_a_q <= 1'b0;
      vld_b_q <= 1'b0;
    end else begin
      vld_a_q <= pix_vld;
      vld_b_q <= vld_a_q;
    end
  end

  curve_lut_loader #(.TOT(TOT), .PTR_W(PTR_W)) u_loader (
    .clk(clk), .rst_n(rst_s), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .wr_data(wr_data), .ptr(ld_ptr), .lo_we(lo_we), .hi_we(hi_we),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .lo_val(lo_val), .hi_val(hi_val)
  );

  curve_lut_store #(.TOT(TOT), .PTR_W(PTR_W)) u_store (
    .clk(clk), .lo_we(lo_we), .hi_we(hi_we), .lo_idx(lo_idx),
    .hi_idx(hi_idx), .lo_val(lo_val), .hi_val(hi_val), .tbl(tbl)
  );

  assign comp_v[0] = pix_r;
  assign comp_v[1] = pix_g;
  assign comp_v[2] = pix_b;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    curve_lut_chan #(
      .N(N), .PIX_W(PIX_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_s),
      .stage_a_en(pix_vld), .stage_b_en(vld_a_q),
      .bypass(!(en_q[c] && active)),
      .comp(comp_v[c]),
      .curve(tbl[c*N +: N]),
      .res(res_v[c])
    );
  end

  assign out_vld = vld_b_q;
  assign out_r   = res_v[0];
  assign out_g   = res_v[1];
  assign out_b   = res_v[2];
endmodule

// File: rtl/curve_lut_chk.sv
module curve_lut_chk #(
  parameter int TOT   = 99,
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_vld,
  input logic             out_vld,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [PTR_W-1:0] ptr
);
  import curve_lut_pkg::*;

  // R4: pointer never passes the end of the blue table
  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(TOT));

  // R2: a data write steps the pointer by two
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DATA && ptr <= PTR_W'(TOT - 2))
    |=> ptr == $past(ptr) + PTR_W'(2));

  // R1: a zero pointer write returns to red point 0
  a_r1_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_PTR && wr_data[PTR_W-1:0] == '0) |=> ptr == '0);

  // R10: each pixel yields a result two cycles later
  a_r10_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> ##1 out_vld);

  // R10: no result without a pixel
  a_r10_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ##1 !out_vld);
endmodule

bind curve_lut curve_lut_chk #(.TOT(TOT), .PTR_W(PTR_W)) i_chk (
  .clk(clk), .rst_n(rst_s), .pix_vld(pix_vld), .out_vld(out_vld),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ld_ptr)
);

// File: tb/test_curve_lut.sv
module test_curve_lut;
  import curve_lut_pkg::*;

  typedef struct {
    int    r;
    int    g;
    int    b;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en_a, wr_en_b;
  logic [1:0] wr_addr;
  logic [31:0] wr_data;
  logic pix_vld;
  logic [9:0] pix_r, pix_g, pix_b;
  logic out_vld_a, out_vld_b;
  logic [15:0] oa_r, oa_g, oa_b, ob_r, ob_g, ob_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_tag = "R11";
  exp_t q_a[$];
  exp_t q_b[$];

  int mdl [2][123];
  int mptr [2];
  bit [2:0] men [2];
  bit marm;

  always #5 clk = ~clk;

  curve_lut #(.CURVE_KIND(0)) i_curve_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .out_vld(out_vld_a), .out_r(oa_r), .out_g(oa_g), .out_b(oa_b)
  );

  curve_lut #(.CURVE_KIND(1)) i_curve_lut_o (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .out_vld(out_vld_b), .out_r(ob_r), .out_g(ob_g), .out_b(ob_b)
  );

  function automatic int npts(input int v);
    return (v != 0) ? 41 : 33;
  endfunction

  // R8/R9 reference: segment, weight, floor, clamp
  function automatic int expv(input int v, input int c, input int comp);
    int n, fw, k, fr, d, base;
    n  = npts(v);
    fw = (v != 0) ? 4 : 5;
    if (!(men[v][c] && (v == 1 || marm))) return comp;
    base = c * n;
    k = comp >> fw;
    if (k >= n - 1) return mdl[v][base + n - 1] & 16'hFFFF;
    fr = comp & ((1 << fw) - 1);
    d  = mdl[v][base + k + 1] - mdl[v][base + k];
    return (mdl[v][base + k] + ((d * fr) >>> fw)) & 16'hFFFF;
  endfunction

  function automatic int gen_a(input int i);
    int c, k;
    c = i / 33; k = i % 33;
    if (c == 0) return k * 512;
    if (c == 1) return k * k * 16;
    return (32 - k) * 512;
  endfunction

  function automatic int gen_b(input int i);
    int c, k;
    c = i / 41; k = i % 41;
    if (c == 0) return k * 25;
    if (c == 1) return (40 - k) * 25;
    return k * k;
  endfunction

  // starts and ends at a falling edge; the model follows R1..R7
  task automatic wr(input int v, input logic [1:0] a, input logic [31:0] d);
    int tot, p;
    tot = 3 * npts(v);
    pix_vld = 1'b0;
    wr_addr = a;
    wr_data = d;
    if (v == 0) wr_en_a = 1'b1; else wr_en_b = 1'b1;
    if (a == REG_CTRL) begin
      if (v == 0) begin men[0] = {d[29], d[28], d[27]}; marm = d[31]; end
      else men[1] = {d[31], d[30], d[29]};
    end else if (a == REG_PTR) begin
      p = int'(d[6:0]);
      mptr[v] = (p > tot) ? tot : p;
    end else if (a == REG_DATA) begin
      if (mptr[v] < tot)     mdl[v][mptr[v]]     = int'(d[15:0]);
      if (mptr[v] + 1 < tot) mdl[v][mptr[v] + 1] = int'(d[31:16]);
      mptr[v] = (mptr[v] + 2 > tot) ? tot : mptr[v] + 2;
    end
    @(negedge clk);
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
  endtask

  task automatic send(input int r, input int g, input int b);
    exp_t e;
    pix_vld = 1'b1;
    pix_r = 10'(r); pix_g = 10'(g); pix_b = 10'(b);
    e.tag = cur_tag;
    e.r = expv(0, 0, r); e.g = expv(0, 1, g); e.b = expv(0, 2, b);
    q_a.push_back(e);
    e.r = expv(1, 0, r); e.g = expv(1, 1, g); e.b = expv(1, 2, b);
    q_b.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    pix_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic load_all(input int v);
    int tot, lo, hi;
    tot = 3 * npts(v);
    wr(v, REG_PTR, 32'd0);
    for (int j = 0; j < (tot + 1) / 2; j++) begin
      lo = (v == 0) ? gen_a(2 * j) : gen_b(2 * j);
      hi = (2 * j + 1 < tot) ? ((v == 0) ? gen_a(2 * j + 1) : gen_b(2 * j + 1)) : 16'hBEEF;
      wr(v, REG_DATA, {16'(hi), 16'(lo)});
    end
    // R4: one more word past the end must be dropped
    wr(v, REG_DATA, 32'hDEAD_CAFE);
  endtask

  task automatic check(input string tag, input string who, input exp_t e,
                       input logic [15:0] r, input logic [15:0] g, input logic [15:0] b);
    checks++;
    if (int'(r) != e.r || int'(g) != e.g || int'(b) != e.b) begin
      fails++;
      $display("FAIL %s %s: got %h/%h/%h expected %h/%h/%h", tag, who, r, g, b,
               16'(e.r), 16'(e.g), 16'(e.b));
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_vld_a) begin
      if (q_a.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 A: result with empty queue, got %h expected none", oa_r);
      end else begin
        e = q_a.pop_front();
        check(e.tag, "A", e, oa_r, oa_g, oa_b);
      end
    end
    if (rst_n && out_vld_b) begin
      if (q_b.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 B: result with empty queue, got %h expected none", ob_r);
      end else begin
        e = q_b.pop_front();
        check(e.tag, "B", e, ob_r, ob_g, ob_b);
      end
    end
  end

  task automatic flag(input bit ok, input string tag, input int got, input int want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0; wr_addr = '0; wr_data = '0;
    pix_vld = 1'b0; pix_r = '0; pix_g = '0; pix_b = '0;
    mptr[0] = 0; mptr[1] = 0; men[0] = 3'b0; men[1] = 3'b0; marm = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    flag(out_vld_a == 1'b0 && out_vld_b == 1'b0, "R11 vld", int'(out_vld_a), 0);
    flag(oa_r == 0 && oa_g == 0 && ob_b == 0, "R11 data", int'(oa_r), 0);
    cur_tag = "R11";
    send(100, 513, 1023);
    idle(1);

    // R10: exact two-cycle latency
    cur_tag = "R10";
    send(7, 8, 9);
    pix_vld = 1'b0;
    flag(out_vld_a == 1'b0, "R10 early", int'(out_vld_a), 0);
    @(negedge clk);
    flag(out_vld_a == 1'b1 && out_vld_b == 1'b1, "R10 on time", int'(out_vld_a), 1);
    idle(3);

    // R3/R4/R5: fill all tables with straddling words
    load_all(0);
    load_all(1);
    wr(0, REG_CTRL, 32'hB800_0000);
    wr(1, REG_CTRL, 32'hE000_0000);

    cur_tag = "R8";
    send(0, 0, 0);
    send(1023, 1023, 1023);
    send(517, 300, 45);
    send(31, 32, 33);
    send(600, 777, 123);
    cur_tag = "R3";
    send(1000, 5, 10);
    send(1023, 31, 2);
    cur_tag = "R4";
    send(0, 500, 1023);
    cur_tag = "R9";
    send(1023, 640, 639);
    cur_tag = "R5";
    send(1000, 639, 20);
    idle(3);

    // R7: arm cleared bypasses the input-curve variant
    cur_tag = "R7";
    wr(0, REG_CTRL, 32'h3800_0000);
    send(300, 400, 500);
    idle(3);

    // R6: single-channel enables at each variant's own field
    cur_tag = "R6";
    wr(0, REG_CTRL, 32'h8800_0000);
    wr(1, REG_CTRL, 32'h3800_0000);
    send(300, 400, 500);
    send(900, 64, 1);
    idle(3);

    // R1/R2: partial reloads through the pointer
    wr(0, REG_CTRL, 32'hB800_0000);
    wr(1, REG_CTRL, 32'hE000_0000);
    wr(0, REG_PTR, 32'd0);
    wr(0, REG_DATA, 32'h1111_0777);
    cur_tag = "R1";
    send(16, 0, 0);
    idle(3);
    wr(0, REG_PTR, 32'd66);
    wr(0, REG_DATA, 32'h2222_3333);
    wr(0, REG_DATA, 32'h0100_0F00);
    wr(1, REG_PTR, 32'd41);
    wr(1, REG_DATA, 32'h0050_0010);
    cur_tag = "R2";
    send(5, 10, 10);
    send(40, 20, 70);
    idle(5);

    flag(q_a.size() == 0 && q_b.size() == 0, "R10 drained", q_a.size() + q_b.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule